// File: doc/BRIEF.md
# Hysteretic Auto-Exposure Controller

This block closes the exposure loop of an image pipeline. Each frame, an upstream statistics unit reports one 8-bit mean luma value with a one-cycle valid strobe. The controller compares that value with a programmable target. It decides whether a correction should begin, continue or end, and it adjusts an exposure value and a global gain value that a downstream sensor driver consumes.

Two thresholds give the loop hysteresis. A wide band must be crossed before a correction begins. A narrower band must be reached before the correction ends. A programmable pacing counter spaces out evaluations. Exposure is moved first. Gain moves only once exposure is pinned at a limit in the required direction. Both values saturate at their limits and never wrap.

Configuration lives in six small registers. A single-cycle write strobe with a select code and 16-bit data updates them.

Top module: `ae_hyst_ctrl`

## Requirements
- R1: After reset, exposure is EXP_INIT (1000), gain is GAIN_INIT (64) and busy is 0. The configuration resets to: target 105, hysteresis 0x0300 (3.0), tolerance 0x0100 (1.0), exposure scale 0x6400 (100.0), gain divisor 0x0400 (4.0), period 3000.
- R2: An evaluation happens only on a cycle where en and stat_vld are both high and at least `period` cycles have passed since the previous evaluation, or since reset. A strobe that arrives earlier is ignored and changes nothing.
- R3: While idle, an evaluation whose absolute error, taken as 8.8, is strictly greater than the hysteresis sets busy and applies one step. An error equal to or below the hysteresis changes nothing.
- R4: While busy, an evaluation whose absolute error is at or below the tolerance clears busy without a step. Otherwise, a further step is applied and busy stays set.
- R5: The error is the target minus the measured luma. A positive error raises the outputs and a negative error lowers them.
- R6: The exposure step is floor(|err| × scale / 256), with a minimum of 1. Exposure saturates at EXP_MIN (1) and EXP_MAX (4000).
- R7: Gain changes only when exposure already sits at EXP_MAX (raising) or EXP_MIN (lowering). The gain step is floor(|err| × 256 / divisor), with a minimum of 1. A divisor of 0 gives the largest step.
- R8: Gain saturates at GAIN_MIN (16) and GAIN_MAX (1023).
- R9: With en low, busy reads 0 from the next cycle on and strobes are ignored. Exposure and gain hold.
- R10: A write with cfg_wr high loads cfg_wdata into the register chosen by cfg_sel: 0 target (bits 7:0), 1 hysteresis, 2 tolerance, 3 exposure scale, 4 gain divisor, 5 period. Select codes 6 and 7 load nothing. A write takes effect from the cycle after its strobe, so an evaluation in the same cycle still uses the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Controller enable |
| stat_vld | input | 1 | Mean-luma statistic valid strobe |
| avg_luma | input | 8 | Measured mean luma |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration register select |
| cfg_wdata | input | 16 | Configuration write data |
| exposure | output | EXP_W | Exposure value |
| gain | output | GAIN_W | Global gain value |
| busy | output | 1 | Correction in progress |

## Verification
A configuration write and an evaluation can fall in the same clock cycle. The bench provokes this by raising cfg_wr, with a new target, on the very cycle that a statistic strobe is honoured. The reference model computes the expected step from the old target and switches its copy of the target only afterwards. A following strobe whose luma equals the new target must then end the correction, which shows that the write did land.

// File: rtl/ae_pkg.sv
// Package: shared types and reset values for the auto-exposure controller.
// Assumes all fixed-point configuration fields are unsigned 8.8.
package ae_pkg;

    typedef enum logic {
        ST_IDLE    = 1'b0,
        ST_CORRECT = 1'b1
    } ae_state_e;

    typedef enum logic [2:0] {
        SEL_TARGET = 3'd0,
        SEL_HYST   = 3'd1,
        SEL_TOL    = 3'd2,
        SEL_ESCALE = 3'd3,
        SEL_GDIV   = 3'd4,
        SEL_PERIOD = 3'd5
    } ae_sel_e;

    typedef struct packed {
        logic [7:0]  target;
        logic [15:0] hyst;
        logic [15:0] tol;
        logic [15:0] exp_scale;
        logic [15:0] gain_div;
        logic [15:0] period;
    } ae_cfg_t;

    localparam logic [7:0]  RST_TARGET = 8'd105;
    localparam logic [15:0] RST_HYST   = 16'h0300;
    localparam logic [15:0] RST_TOL    = 16'h0100;
    localparam logic [15:0] RST_ESCALE = 16'h6400;
    localparam logic [15:0] RST_GDIV   = 16'h0400;
    localparam logic [15:0] RST_PERIOD = 16'd3000;

endpackage

// File: rtl/ae_cfg_regs.sv
// Module: configuration store for the controller.
// Holds six registers loaded by a one-cycle write strobe. Unused select
// codes are dropped. Assumes the writer holds data stable for the strobe.
module ae_cfg_regs
    import ae_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr,
    input  logic [2:0]  sel,
    input  logic [15:0] wdata,
    output ae_cfg_t     cfg
);

    // Load the selected register, or restore the reset values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg.target    <= RST_TARGET;
            cfg.hyst      <= RST_HYST;
            cfg.tol       <= RST_TOL;
            cfg.exp_scale <= RST_ESCALE;
            cfg.gain_div  <= RST_GDIV;
            cfg.period    <= RST_PERIOD;
        end else if (wr) begin
            case (sel)
                SEL_TARGET: cfg.target    <= wdata[7:0];
                SEL_HYST:   cfg.hyst      <= wdata;
                SEL_TOL:    cfg.tol       <= wdata;
                SEL_ESCALE: cfg.exp_scale <= wdata;
                SEL_GDIV:   cfg.gain_div  <= wdata;
                SEL_PERIOD: cfg.period    <= wdata;
                default:    ;
            endcase
        end
    end

endmodule

// File: rtl/ae_pace.sv
// Module: evaluation pacing counter.
// Counts cycles since the last evaluation and saturates at the period.
// An evaluation restarts the count from zero.
// Assumes that the period only shrinks, or changes while the count is low.
module ae_pace #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] period,
    input  logic             restart,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    // Advance the saturating count, or clear it on an evaluation.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt_q <= '0;
        end else if (cnt_q < period) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // The window is open once the count has reached the period.
    always_comb expired = (cnt_q >= period);

endmodule

// File: rtl/ae_err_calc.sv
// Module: error magnitude and threshold compare.
// Forms target minus luma, its sign and magnitude, and compares the
// magnitude, as 8.8, against the hysteresis and tolerance bands.
module ae_err_calc (
    input  logic [7:0]  target,
    input  logic [7:0]  luma,
    input  logic [15:0] hyst,
    input  logic [15:0] tol,
    output logic        dir_up,
    output logic [7:0]  err_mag,
    output logic        over_hyst,
    output logic        within_tol
);

    logic [8:0]  diff;
    logic [8:0]  mag9;
    logic [15:0] mag_fx;

    // Signed difference, then its magnitude.
    always_comb begin
        diff    = {1'b0, target} - {1'b0, luma};
        dir_up  = ~diff[8];
        mag9    = diff[8] ? (9'd0 - diff) : diff;
        err_mag = mag9[7:0];
    end

    // Band compares on the 8.8 magnitude.
    always_comb begin
        mag_fx     = {err_mag, 8'h00};
        over_hyst  = (mag_fx > hyst);
        within_tol = (mag_fx <= tol);
    end

endmodule

// File: rtl/ae_step.sv
// Module: next exposure and gain values for one correction step.
// Moves exposure first, and moves gain only when exposure is already
// at the limit in the wanted direction. Every result saturates.
// Purely combinational. Assumes a nonzero error magnitude.
module ae_step #(
    parameter int EXP_W    = 16,
    parameter int EXP_MIN  = 1,
    parameter int EXP_MAX  = 4000,
    parameter int GAIN_W   = 10,
    parameter int GAIN_MIN = 16,
    parameter int GAIN_MAX = 1023
) (
    input  logic              dir_up,
    input  logic [7:0]        err_mag,
    input  logic [15:0]       exp_scale,
    input  logic [15:0]       gain_div,
    input  logic [EXP_W-1:0]  exp_cur,
    input  logic [GAIN_W-1:0] gain_cur,
    output logic [EXP_W-1:0]  exp_nxt,
    output logic [GAIN_W-1:0] gain_nxt
);

    localparam int PROD_W = 24;
    localparam logic [31:0] EMIN = 32'(EXP_MIN);
    localparam logic [31:0] EMAX = 32'(EXP_MAX);
    localparam logic [31:0] GMIN = 32'(GAIN_MIN);
    localparam logic [31:0] GMAX = 32'(GAIN_MAX);

    logic [PROD_W-1:0] prod;
    logic [15:0]       e_step;
    logic [15:0]       g_num;
    logic [15:0]       g_quo;
    logic [15:0]       g_step;
    logic [31:0]       e_wide;
    logic [31:0]       g_wide;
    logic              e_pinned;

    // Exposure step: magnitude times the 8.8 scale, at least one.
    always_comb begin
        prod   = PROD_W'(err_mag) * PROD_W'(exp_scale);
        e_step = 16'(prod >> 8);
        if (e_step == 16'd0) e_step = 16'd1;
    end

    // Gain step: magnitude over the 8.8 divisor, at least one.
    always_comb begin
        g_num  = {err_mag, 8'h00};
        g_quo  = (gain_div == 16'd0) ? 16'hFFFF : (g_num / gain_div);
        g_step = (g_quo == 16'd0) ? 16'd1 : g_quo;
    end

    // Exposure is pinned when it already sits at the limit it heads for.
    always_comb begin
        e_wide   = 32'(exp_cur);
        g_wide   = 32'(gain_cur);
        e_pinned = dir_up ? (e_wide >= EMAX) : (e_wide <= EMIN);
    end

    // Choose which value moves, and clamp it to its range.
    always_comb begin
        exp_nxt  = exp_cur;
        gain_nxt = gain_cur;
        if (!e_pinned) begin
            if (dir_up) begin
                exp_nxt = (e_wide + 32'(e_step) > EMAX) ? EXP_W'(EMAX)
                                                        : EXP_W'(e_wide + 32'(e_step));
            end else begin
                exp_nxt = (e_wide < EMIN + 32'(e_step)) ? EXP_W'(EMIN)
                                                        : EXP_W'(e_wide - 32'(e_step));
            end
        end else begin
            if (dir_up) begin
                gain_nxt = (g_wide + 32'(g_step) > GMAX) ? GAIN_W'(GMAX)
                                                         : GAIN_W'(g_wide + 32'(g_step));
            end else begin
                gain_nxt = (g_wide < GMIN + 32'(g_step)) ? GAIN_W'(GMIN)
                                                         : GAIN_W'(g_wide - 32'(g_step));
            end
        end
    end

endmodule

// File: rtl/ae_hyst_ctrl.sv
// Module: top of the hysteretic auto-exposure controller.
// Evaluates each paced, enabled statistic strobe. It starts a correction
// when the error leaves the hysteresis band and ends it once the error is
// inside the tolerance band. It registers exposure, gain and the state.
// Assumes stat_vld is a single-cycle strobe per frame.
module ae_hyst_ctrl
    import ae_pkg::*;
#(
    parameter int EXP_W     = 16,
    parameter int EXP_MIN   = 1,
    parameter int EXP_MAX   = 4000,
    parameter int EXP_INIT  = 1000,
    parameter int GAIN_W    = 10,
    parameter int GAIN_MIN  = 16,
    parameter int GAIN_MAX  = 1023,
    parameter int GAIN_INIT = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              stat_vld,
    input  logic [7:0]        avg_luma,
    input  logic              cfg_wr,
    input  logic [2:0]        cfg_sel,
    input  logic [15:0]       cfg_wdata,
    output logic [EXP_W-1:0]  exposure,
    output logic [GAIN_W-1:0] gain,
    output logic              busy
);

    ae_cfg_t           cfg;
    ae_state_e         state_q;
    logic              expired;
    logic              eval;
    logic              dir_up;
    logic [7:0]        err_mag;
    logic              over_hyst;
    logic              within_tol;
    logic [EXP_W-1:0]  exp_nxt;
    logic [GAIN_W-1:0] gain_nxt;

    ae_cfg_regs u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (cfg_wr),
        .sel   (cfg_sel),
        .wdata (cfg_wdata),
        .cfg   (cfg)
    );

    ae_pace #(.CNT_W(16)) u_pace (
        .clk     (clk),
        .rst_n   (rst_n),
        .period  (cfg.period),
        .restart (eval),
        .expired (expired)
    );

    ae_err_calc u_err (
        .target     (cfg.target),
        .luma       (avg_luma),
        .hyst       (cfg.hyst),
        .tol        (cfg.tol),
        .dir_up     (dir_up),
        .err_mag    (err_mag),
        .over_hyst  (over_hyst),
        .within_tol (within_tol)
    );

    ae_step #(
        .EXP_W    (EXP_W),
        .EXP_MIN  (EXP_MIN),
        .EXP_MAX  (EXP_MAX),
        .GAIN_W   (GAIN_W),
        .GAIN_MIN (GAIN_MIN),
        .GAIN_MAX (GAIN_MAX)
    ) u_step (
        .dir_up    (dir_up),
        .err_mag   (err_mag),
        .exp_scale (cfg.exp_scale),
        .gain_div  (cfg.gain_div),
        .exp_cur   (exposure),
        .gain_cur  (gain),
        .exp_nxt   (exp_nxt),
        .gain_nxt  (gain_nxt)
    );

    // An evaluation needs enable, a fresh statistic and an open window.
    always_comb eval = en && stat_vld && expired;

    // State and output registers: start, continue or finish a correction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            exposure <= EXP_W'(EXP_INIT);
            gain     <= GAIN_W'(GAIN_INIT);
        end else if (!en) begin
            state_q <= ST_IDLE;
        end else if (eval) begin
            case (state_q)
                ST_IDLE: begin
                    if (over_hyst) begin
                        state_q  <= ST_CORRECT;
                        exposure <= exp_nxt;
                        gain     <= gain_nxt;
                    end
                end
                ST_CORRECT: begin
                    if (within_tol) begin
                        state_q <= ST_IDLE;
                    end else begin
                        exposure <= exp_nxt;
                        gain     <= gain_nxt;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Busy mirrors the correcting state.
    always_comb busy = (state_q == ST_CORRECT);

endmodule

// File: rtl/ae_hyst_ctrl_chk.sv
// Module: property checker for ae_hyst_ctrl, attached with bind.
// Observes ports only; it drives nothing.
module ae_hyst_ctrl_chk #(
    parameter int EXP_W    = 16,
    parameter int EXP_MIN  = 1,
    parameter int EXP_MAX  = 4000,
    parameter int GAIN_W   = 10,
    parameter int GAIN_MIN = 16,
    parameter int GAIN_MAX = 1023
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic              stat_vld,
    input logic [EXP_W-1:0]  exposure,
    input logic [GAIN_W-1:0] gain,
    input logic              busy
);

    // R9: a low enable clears busy in the next cycle.
    a_r9_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !busy);

    // R9: with en low, exposure and gain hold.
    a_r9_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(exposure) && $stable(gain)));

    // R2: without a strobe, exposure and gain hold.
    a_r2_hold_without_vld: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_vld |=> ($stable(exposure) && $stable(gain)));

    // R3: busy rises only after an enabled strobe.
    a_r3_start_needs_vld: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stat_vld && en));

    // R6: exposure stays inside its limits.
    a_r6_exp_range: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(exposure) >= EXP_MIN) && (int'(exposure) <= EXP_MAX));

    // R8: gain stays inside its limits.
    a_r8_gain_range: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(gain) >= GAIN_MIN) && (int'(gain) <= GAIN_MAX));

    // R7: gain moves only while exposure is pinned at a limit.
    a_r7_gain_after_exp: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(gain) |-> ($stable(exposure) &&
            ((int'(exposure) == EXP_MAX) || (int'(exposure) == EXP_MIN))));

endmodule

bind ae_hyst_ctrl ae_hyst_ctrl_chk #(
    .EXP_W    (EXP_W),
    .EXP_MIN  (EXP_MIN),
    .EXP_MAX  (EXP_MAX),
    .GAIN_W   (GAIN_W),
    .GAIN_MIN (GAIN_MIN),
    .GAIN_MAX (GAIN_MAX)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .stat_vld (stat_vld),
    .exposure (exposure),
    .gain     (gain),
    .busy     (busy)
);

// File: tb/ae_hyst_ctrl_tb.sv
// Scoreboard bench for ae_hyst_ctrl. A driver task runs a reference model,
// queues the expected outputs, and a monitor compares them when due.
module ae_hyst_ctrl_tb;

    localparam int EMIN = 1, EMAX = 4000, EINIT = 1000;
    localparam int GMIN = 16, GMAX = 1023, GINIT = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b1;
    logic        stat_vld = 1'b0;
    logic [7:0]  avg_luma = 8'd0;
    logic        cfg_wr = 1'b0;
    logic [2:0]  cfg_sel = 3'd0;
    logic [15:0] cfg_wdata = 16'd0;
    logic [15:0] exposure;
    logic [9:0]  gain;
    logic        busy;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 0;

    // Reference model state.
    int m_exp = EINIT, m_gain = GINIT, m_last = 0;
    bit m_busy = 0;
    int c_target = 105, c_hyst = 'h300, c_tol = 'h100;
    int c_scale = 'h6400, c_div = 'h400, c_period = 3000;

    typedef struct {
        int    due;
        int    e;
        int    g;
        bit    b;
        string req;
    } item_t;
    item_t exp_q[$];

    ae_hyst_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .en(en), .stat_vld(stat_vld),
        .avg_luma(avg_luma), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .exposure(exposure), .gain(gain), .busy(busy)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input int act, input int expv, input string what);
        n_chk++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // Reference step for one honoured evaluation.
    task automatic model_eval(input int luma);
        int err, mag, es, gs;
        bit up;
        bit act;
        err = c_target - luma;
        mag = (err < 0) ? -err : err;
        up  = (err >= 0);
        act = 0;
        if (!m_busy) begin
            if (mag * 256 > c_hyst) begin m_busy = 1; act = 1; end
        end else begin
            if (mag * 256 <= c_tol) m_busy = 0;
            else act = 1;
        end
        if (act) begin
            es = (mag * c_scale) / 256;
            if (es == 0) es = 1;
            gs = (c_div == 0) ? 65535 : (mag * 256) / c_div;
            if (gs == 0) gs = 1;
            if (up) begin
                if (m_exp < EMAX) m_exp = (m_exp + es > EMAX) ? EMAX : m_exp + es;
                else m_gain = (m_gain + gs > GMAX) ? GMAX : m_gain + gs;
            end else begin
                if (m_exp > EMIN) m_exp = (m_exp - es < EMIN) ? EMIN : m_exp - es;
                else m_gain = (m_gain - gs < GMIN) ? GMIN : m_gain - gs;
            end
        end
    endtask

    task automatic apply_cfg(input int sel, input int d);
        case (sel)
            0: c_target = d & 'hFF;
            1: c_hyst   = d;
            2: c_tol    = d;
            3: c_scale  = d;
            4: c_div    = d;
            5: c_period = d;
            default: ;
        endcase
    endtask

    // Driver: one strobe, optionally with a config write in the same cycle.
    // Starts and ends just after a falling edge.
    task automatic drive(input int luma, input bit wr, input int sel, input int d, input string req);
        item_t it;
        if (en && (cyc - m_last >= c_period)) begin
            model_eval(luma);
            m_last = cyc + 1;
        end
        it.due = cyc + 1; it.e = m_exp; it.g = m_gain; it.b = m_busy; it.req = req;
        exp_q.push_back(it);
        avg_luma  = 8'(luma);
        stat_vld  = 1'b1;
        cfg_wr    = wr;
        cfg_sel   = 3'(sel);
        cfg_wdata = 16'(d);
        @(negedge clk);
        stat_vld = 1'b0;
        cfg_wr   = 1'b0;
        if (wr) apply_cfg(sel, d);
    endtask

    task automatic pulse(input int luma, input string req);
        drive(luma, 1'b0, 0, 0, req);
    endtask

    task automatic write_cfg(input int sel, input int d);
        cfg_wr = 1'b1; cfg_sel = 3'(sel); cfg_wdata = 16'(d);
        @(negedge clk);
        cfg_wr = 1'b0;
        apply_cfg(sel, d);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: pop and compare the expected items that are due.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (exp_q.size() > 0 && exp_q[0].due <= cyc) begin
                item_t it;
                it = exp_q.pop_front();
                check(it.req, int'(exposure), it.e, "exposure");
                check(it.req, int'(gain), it.g, "gain");
                check(it.req, int'(busy), int'(it.b), "busy");
            end
        end
    end

    // Watchdog.
    initial begin
        #(20 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        m_last = cyc;
        // R1 reset state
        check("R1", int'(exposure), EINIT, "exposure");
        check("R1", int'(gain), GINIT, "gain");
        check("R1", int'(busy), 0, "busy");
        // R2: too early after reset, ignored
        pulse(50, "R2 early strobe");
        idle(3000);
        // R1/R3: default target 105, hysteresis 3.0, error 3 not above
        pulse(102, "R1 R3 equal to hysteresis");
        // R10: shorter period
        write_cfg(5, 4);
        idle(4);
        pulse(101, "R3 R5 R6 start step");
        idle(3);
        pulse(103, "R2 window not open");
        pulse(103, "R4 continue above tolerance");
        idle(4);
        pulse(104, "R4 stop at tolerance");
        idle(4);
        pulse(102, "R3 idle within hysteresis");
        idle(4);
        pulse(120, "R5 negative error lowers");
        idle(4);
        pulse(200, "R6 exposure floor");
        idle(4);
        pulse(200, "R7 gain down after floor");
        idle(4);
        pulse(200, "R7 gain down again");
        idle(4);
        pulse(200, "R8 gain floor");
        idle(4);
        pulse(105, "R4 zero error ends");
        idle(4);
        pulse(0, "R6 exposure ceiling");
        idle(4);
        pulse(0, "R7 gain up after ceiling");
        write_cfg(4, 0);
        idle(4);
        pulse(0, "R7 zero divisor step");
        idle(4);
        pulse(0, "R8 gain ceiling");
        write_cfg(3, 1);
        idle(4);
        pulse(95, "R6 minimum step");
        // R9: enable low
        en = 1'b0;
        idle(1);
        check("R9", int'(busy), 0, "busy");
        check("R9", int'(exposure), m_exp, "exposure");
        m_busy = 0;
        idle(4);
        pulse(0, "R9 strobe while disabled");
        en = 1'b1;
        write_cfg(3, 'h6400);
        write_cfg(7, 5);
        idle(4);
        // R10: write in the same cycle as an evaluation uses the old target
        drive(100, 1'b1, 0, 200, "R10 same-cycle write");
        idle(4);
        pulse(200, "R10 new target in effect");
        idle(4);
        pulse(190, "R10 R6 later step");
        idle(4);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule